// File: doc/BRIEF.md
# Redundant Pipeline Stage Code Corrector

This block is the digital back end of a pipelined converter built from fourteen 1.5-bit stages. Each stage reports a three-level decision for a sample, and the stages work on the same sample one after another, so stage k reports its code k cycles after stage 0. The block deskews the codes so that all decisions for one sample meet in the same cycle. It then adds them with overlapping binary weights, because each inter-stage gain of two halves the weight of the next stage. This removes the redundancy and gives one corrected 14-bit word per clock.

A sample is announced by `valid_i` in the cycle in which stage 0's code is on the bus. The corrected word comes out with a fixed latency and a matching `valid_o` pulse. A stage code of 11 cannot come from a correct stage. The block treats such a code as 10 and keeps a sticky error flag.

Top module: `adc_err_corr`

## Requirements
- R1: A `valid_i` sampled high at clock edge m gives `valid_o` high during exactly the cycle that follows edge m+N-1, with N = 14 stages. A sample launches one output pulse.
- R2: The sample launched at edge m uses the code of stage k as sampled at edge m+k. Stage k occupies `codes_i[2k+1:2k]`, and stage 0 is the most significant. Codes that other lanes carry in other cycles have no effect on that sample.
- R3: With legal codes c_k in {00, 01, 10}, the output is `data_o` = sum over k of c_k·2^(N-1-k), minus (2^(N-1)-1). When every stage reports 01, the output is 8192.
- R4: When the sum falls below the offset, `data_o` saturates at 0. For example, all stages 00 give 0.
- R5: When the result would exceed 16383, `data_o` saturates at 16383. For example, all stages 10 give 16383.
- R6: A stage code 11 gives the same output as the code 10 in that stage.
- R7: Once `codes_i` carries 11 in any lane at a clock edge, `err_o` reads 1 from the next cycle on. Only reset clears it.
- R8: `data_o` keeps its last value in every cycle in which `valid_o` is low.
- R9: While `rst_ni` is low, `valid_o`, `data_o` and `err_o` read 0. Samples that were in flight before the reset do not come out.
- R10: Samples launched on consecutive clock edges each give their own correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks the cycle in which stage 0 holds a new sample's code |
| codes_i | input | 28 | Stage codes, stage k in bits [2k+1:2k] |
| data_o | output | 14 | Corrected, saturated sample |
| valid_o | output | 1 | Marks a new corrected sample |
| err_o | output | 1 | Sticky illegal-code flag |

## Verification
A lane delayed by the wrong number of registers picks up a neighbouring cycle's code. The next output word is then wrong by a multiple of that stage's weight. The tests fill unused lane slots with nonzero codes so that this shows up in the first sample. A broken valid delay shifts or drops the `valid_o` pulse relative to edge m+N-1, and this is visible in the cycle in which the sample is due. A wrong offset or a wrong saturation bound shows up at once in the midscale and full-scale words. A lost sticky bit shows up the cycle after a later legal sample.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  typedef logic [1:0] stage_code_t;

  localparam stage_code_t CODE_TOP = 2'b10;

  function automatic stage_code_t clamp_code(stage_code_t c);
    return (c == 2'b11) ? CODE_TOP : c;
  endfunction
endpackage

// File: rtl/stage_sanitize.sv
module stage_sanitize
  import adc_corr_pkg::*;
#(
  parameter int N_STAGES = 14
) (
  input  logic [2*N_STAGES-1:0] codes_i,
  output logic [2*N_STAGES-1:0] codes_o,
  output logic                  illegal_o
);
  logic [N_STAGES-1:0] bad;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_lane
    assign codes_o[2*k +: 2] = clamp_code(codes_i[2*k +: 2]);
    assign bad[k]            = &codes_i[2*k +: 2];
  end

  assign illegal_o = |bad;
endmodule

// File: rtl/deskew_line.sv
module deskew_line #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] sr [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
      end else begin
        sr[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
      end
    end

    assign q_o = sr[DEPTH-1];
  end
endmodule

// File: rtl/overlap_adder.sv
module overlap_adder #(
  parameter int N_STAGES = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2*N_STAGES-1:0] codes_i,
  output logic                  valid_o,
  output logic [N_STAGES-1:0]   data_o
);
  localparam int SUM_W    = N_STAGES + 1;
  localparam int DIFF_W   = SUM_W + 1;
  localparam int OFFSET   = (2 ** (N_STAGES - 1)) - 1;
  localparam int MAX_CODE = (2 ** N_STAGES) - 1;

  logic [SUM_W-1:0]         sum;
  logic signed [DIFF_W-1:0] diff;
  logic [N_STAGES-1:0]      sat;

  always_comb begin
    sum = '0;
    for (int k = 0; k < N_STAGES; k++)
      sum = sum + (SUM_W'(codes_i[2*k +: 2]) << (N_STAGES - 1 - k));
  end

  always_comb begin
    diff = $signed({1'b0, sum}) - $signed(DIFF_W'(OFFSET));
    if (diff < 0)                               sat = '0;
    else if (diff > $signed(DIFF_W'(MAX_CODE))) sat = '1;
    else                                        sat = diff[N_STAGES-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sat;
    end
  end
endmodule

// File: rtl/adc_err_corr.sv
module adc_err_corr #(
  parameter int N_STAGES = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2*N_STAGES-1:0] codes_i,
  output logic [N_STAGES-1:0]   data_o,
  output logic                  valid_o,
  output logic                  err_o
);
  logic [2*N_STAGES-1:0] clean;
  logic [2*N_STAGES-1:0] aligned;
  logic                  illegal;
  logic                  valid_al;
  logic                  err_q;

  stage_sanitize #(.N_STAGES(N_STAGES)) u_san (
    .codes_i  (codes_i),
    .codes_o  (clean),
    .illegal_o(illegal)
  );

  // stage k arrives k cycles late; pad it to line up with the last stage
  for (genvar k = 0; k < N_STAGES; k++) begin : g_deskew
    deskew_line #(.W(2), .DEPTH(N_STAGES - 1 - k)) u_dl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (clean[2*k +: 2]),
      .q_o   (aligned[2*k +: 2])
    );
  end

  deskew_line #(.W(1), .DEPTH(N_STAGES - 1)) u_vdl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (valid_i),
    .q_o   (valid_al)
  );

  overlap_adder #(.N_STAGES(N_STAGES)) u_add (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_al),
    .codes_i(aligned),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | illegal;
  end

  assign err_o = err_q;
endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk #(
  parameter int N_STAGES = 14
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [2*N_STAGES-1:0] codes_i,
  input logic [N_STAGES-1:0]   data_o,
  input logic                  valid_o,
  input logic                  err_o
);
  int unsigned since_rst;
  logic        any_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst <= 0;
    else if (since_rst < N_STAGES) since_rst <= since_rst + 1;
  end

  always_comb begin
    any_bad = 1'b0;
    for (int k = 0; k < N_STAGES; k++)
      if (codes_i[2*k +: 2] == 2'b11) any_bad = 1'b1;
  end

  // R1
  no_early_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> since_rst >= N_STAGES);

  // R8
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  // R7
  sticky_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R7
  raise_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_bad |=> err_o);

  // R1
  valid_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({valid_o, err_o}) && (valid_i || !valid_i));
endmodule

bind adc_err_corr adc_corr_chk #(.N_STAGES(N_STAGES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .codes_i(codes_i),
  .data_o (data_o),
  .valid_o(valid_o),
  .err_o  (err_o)
);

// File: tb/adc_err_corr_test.sv
module adc_err_corr_test;
  localparam int PERIOD = 10;
  localparam int N      = 14;
  localparam int CYC    = 64;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [2*N-1:0] codes_i = '0;
  logic [N-1:0]   data_o;
  logic           valid_o;
  logic           err_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [2*N-1:0] cyc_codes [CYC];
  logic           cyc_valid [CYC];
  logic           obs_v     [CYC];
  int             obs_d     [CYC];

  adc_err_corr #(.N_STAGES(N)) uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .codes_i(codes_i),
    .data_o (data_o),
    .valid_o(valid_o),
    .err_o  (err_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_word(logic [2*N-1:0] f);
    int s = 0;
    for (int k = 0; k < N; k++) begin
      int c = int'(f[2*k +: 2]);
      if (c == 3) c = 2;
      s += c << (N - 1 - k);
    end
    s -= (1 << (N - 1)) - 1;
    if (s < 0) s = 0;
    if (s > (1 << N) - 1) s = (1 << N) - 1;
    return s;
  endfunction

  function automatic logic [2*N-1:0] pat(int p);
    logic [2*N-1:0] f;
    for (int k = 0; k < N; k++) f[2*k +: 2] = 2'((p + k * (p + 1)) % 3);
    return f;
  endfunction

  function automatic logic [2*N-1:0] fill(logic [1:0] c);
    logic [2*N-1:0] f;
    for (int k = 0; k < N; k++) f[2*k +: 2] = c;
    return f;
  endfunction

  task automatic clear_sched(logic [1:0] junk);
    for (int c = 0; c < CYC; c++) begin
      cyc_codes[c] = fill(junk);
      cyc_valid[c] = 1'b0;
    end
  endtask

  task automatic add_sample(int start, logic [2*N-1:0] f);
    cyc_valid[start] = 1'b1;
    for (int k = 0; k < N; k++) cyc_codes[start + k][2*k +: 2] = f[2*k +: 2];
  endtask

  task automatic play(int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk_i);
      if (c > 0) begin
        obs_v[c-1] = valid_o;
        obs_d[c-1] = int'(data_o);
      end
      valid_i = cyc_valid[c];
      codes_i = cyc_codes[c];
    end
    @(negedge clk_i);
    obs_v[ncyc-1] = valid_o;
    obs_d[ncyc-1] = int'(data_o);
    valid_i = 1'b0;
  endtask

  task automatic verify_out(string req, int start, logic [2*N-1:0] f);
    chk({req, " valid"}, int'(obs_v[start + N - 1]), 1);
    chk({req, " data"}, obs_d[start + N - 1], exp_word(f));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R9 valid_o in reset", int'(valid_o), 0);
    chk("R9 data_o in reset", int'(data_o), 0);
    chk("R9 err_o in reset", int'(err_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
  endtask

  task automatic t_midscale();
    clear_sched(2'b00);
    add_sample(2, fill(2'b01));
    play(40);
    chk("R1 no early valid", int'(obs_v[2 + N - 2]), 0);
    verify_out("R3 midscale", 2, fill(2'b01));
    chk("R3 midscale literal", obs_d[2 + N - 1], 8192);
    chk("R1 single pulse", int'(obs_v[2 + N]), 0);
    for (int c = 2 + N; c < 40; c++) begin
      if (obs_d[c] != 8192 || obs_v[c]) begin
        chk("R8 hold after pulse", obs_d[c], 8192);
        break;
      end
    end
    chk("R8 hold end", obs_d[39], 8192);
  endtask

  task automatic t_saturation();
    clear_sched(2'b00);
    add_sample(1, fill(2'b00));
    add_sample(20, fill(2'b10));
    play(40);
    verify_out("R4 low sat", 1, fill(2'b00));
    chk("R4 low literal", obs_d[1 + N - 1], 0);
    verify_out("R5 high sat", 20, fill(2'b10));
    chk("R5 high literal", obs_d[20 + N - 1], 16383);
  endtask

  task automatic t_alignment();
    logic [2*N-1:0] f;
    f = pat(5);
    clear_sched(2'b10);
    add_sample(3, fill(2'b00));
    play(40);
    verify_out("R2 zeros among junk", 3, fill(2'b00));
    clear_sched(2'b00);
    add_sample(3, f);
    play(40);
    verify_out("R2 pattern", 3, f);
  endtask

  task automatic t_back_to_back();
    clear_sched(2'b01);
    for (int s = 0; s < 5; s++) add_sample(2 + s, pat(s + 1));
    play(45);
    for (int s = 0; s < 5; s++) verify_out("R10 consecutive", 2 + s, pat(s + 1));
    chk("R3 generic pattern", obs_d[2 + N - 1], exp_word(pat(1)));
    chk("R10 err clean", int'(err_o), 0);
  endtask

  task automatic t_illegal();
    logic [2*N-1:0] f, g;
    f = fill(2'b01);
    f[2*5 +: 2] = 2'b11;
    g = fill(2'b01);
    g[2*5 +: 2] = 2'b10;
    clear_sched(2'b00);
    add_sample(2, f);
    add_sample(20, fill(2'b01));
    play(40);
    chk("R6 illegal as 10", obs_d[2 + N - 1], exp_word(g));
    chk("R6 valid", int'(obs_v[2 + N - 1]), 1);
    chk("R7 sticky err", int'(err_o), 1);
    verify_out("R7 later legal sample", 20, fill(2'b01));
  endtask

  task automatic t_reset_clear();
    clear_sched(2'b00);
    add_sample(1, fill(2'b10));
    play(6);
    do_reset();
    clear_sched(2'b00);
    play(30);
    for (int c = 0; c < 30; c++) begin
      if (obs_v[c]) begin
        chk("R9 flushed sample", int'(obs_v[c]), 0);
        break;
      end
    end
    chk("R9 err cleared", int'(err_o), 0);
    chk("R9 data after flush", obs_d[29], 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_midscale();
    t_saturation();
    t_alignment();
    t_back_to_back();
    t_illegal();
    t_reset_clear();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule